// File: doc/BRIEF.md
# In-order pipeline hazard scoreboard

This block records the destination registers of instructions that have left register fetch but not yet finished writeback in an in-order pipeline. Register fetch asks it, every cycle, whether either of the current instruction's two source registers is still waiting to be written. If so, the instruction holds its place and the stage stalls. When it leaves register fetch, the instruction inserts its destination register. Writeback removes entries one at a time.

Entries sit in a small circular buffer in program order, so a removal always retires the oldest one. Instructions with no destination still take a slot, marked as carrying no register, so that the order stays intact. Instructions squashed by a misprediction keep their slot. They travel to writeback marked as poisoned and release the slot there like any other instruction. The only remover is writeback, so two stages never compete for removal and no slot is ever freed out of order. The register file, the forwarding paths and the poisoning logic itself belong to the surrounding pipeline.

Top module: `hazard_scoreboard`

## Requirements
- R1: After reset `empty_o` is 1, `full_o` is 0, and no source index gives a hit.
- R2: `hit0_o` is 1 exactly when `src0_i` is nonzero and equals the destination of at least one pending entry that carries a register.
- R3: `hit1_o` follows the same rule for `src1_i`, independently of `src0_i`, and `stall_o` is the OR of `hit0_o` and `hit1_o`.
- R4: Register index 0 never gives a hit. An entry inserted with `ins_has_dst_i` = 0 never gives a hit but still occupies a slot.
- R5: A removal retires the oldest entry only. Its register stops hitting from the next cycle, unless a younger entry holds the same register, and younger entries keep hitting.
- R6: `full_o` is 1 once DEPTH (default 4) entries are pending. An insert request while `full_o` is 1 is discarded, even if a removal happens in the same cycle.
- R7: A removal request while `empty_o` is 1 has no effect. The block stays empty and later inserts behave normally.
- R8: The hit outputs reflect the state at the start of the cycle. An entry being removed in the current cycle still hits. An entry being inserted in the current cycle hits from the next cycle.
- R9: When the buffer is neither full nor empty, an insert and a removal in the same cycle both take effect: the oldest entry leaves, the new entry becomes the youngest, and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ins_valid_i | input | 1 | Insert request from register fetch |
| ins_has_dst_i | input | 1 | Inserted instruction writes a register |
| ins_dst_i | input | 5 | Destination register index of the inserted instruction |
| rem_valid_i | input | 1 | Writeback retires the oldest entry |
| src0_i | input | 5 | First source register to search |
| src1_i | input | 5 | Second source register to search |
| hit0_o | output | 1 | First source matches a pending write |
| hit1_o | output | 1 | Second source matches a pending write |
| stall_o | output | 1 | Either source matches; register fetch must hold |
| full_o | output | 1 | No free slot; insert is refused |
| empty_o | output | 1 | No pending entry; remove is ignored |

## Verification
The assertions check the following on every cycle:
- full and empty are never both set;
- an insert while full leaves the buffer full;
- a removal while empty leaves it empty;
- a write never lands on an occupied slot;
- index 0 never hits;
- an empty buffer never stalls.

Only the bench scenarios can show the correctness of the search itself: the hit value for every source index against a known set of pending registers, oldest-first retirement, and same-cycle insert or removal being invisible to the search. The bench compares every output on every cycle against an ordered model that it keeps itself.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  localparam int unsigned REG_IDX_W = 5;

  typedef struct packed {
    logic                 occ;      // slot holds an in-flight instruction
    logic                 has_dst;  // instruction writes a register
    logic [REG_IDX_W-1:0] dst;
  } sb_entry_t;
endpackage

// File: rtl/hsb_ptr_ctrl.sv
module hsb_ptr_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ins_req_i,
  input  logic          rem_req_i,
  output logic          ins_fire_o,
  output logic          rem_fire_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full_o     = (cnt_q == CW'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign ins_fire_o = ins_req_i & ~full_o;
  assign rem_fire_o = rem_req_i & ~empty_o;
  assign wr_ptr_o   = wr_q;
  assign rd_ptr_o   = rd_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (ins_fire_o) wr_q <= bump(wr_q);
      if (rem_fire_o) rd_q <= bump(rd_q);
      case ({ins_fire_o, rem_fire_o})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_full_empty_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && ins_req_i && !rem_req_i) |=> full_o);
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rem_req_i && !ins_req_i) |=> empty_o);
endmodule

// File: rtl/hsb_slot.sv
module hsb_slot
  import hsb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 clr_en_i,
  input  logic                 has_dst_i,
  input  logic [REG_IDX_W-1:0] dst_i,
  output sb_entry_t            ent_o
);
  sb_entry_t ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
    end else if (wr_en_i) begin
      ent_q.occ     <= 1'b1;
      ent_q.has_dst <= has_dst_i;
      ent_q.dst     <= dst_i;
    end else if (clr_en_i) begin
      ent_q.occ <= 1'b0;
    end
  end

  assign ent_o = ent_q;

  // Pointer control must never aim a write at a live slot
  p_no_clobber_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !ent_q.occ);
endmodule

// File: rtl/hsb_match.sv
module hsb_match
  import hsb_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  sb_entry_t            ent_i [DEPTH],
  input  logic [REG_IDX_W-1:0] src_i,
  output logic                 hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_i[i].occ && ent_i[i].has_dst && (ent_i[i].dst == src_i))
        hit_o = 1'b1;
    end
    if (src_i == '0) hit_o = 1'b0;
  end
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard
  import hsb_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned NUM_SRC = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ins_valid_i,
  input  logic                 ins_has_dst_i,
  input  logic [REG_IDX_W-1:0] ins_dst_i,
  input  logic                 rem_valid_i,
  input  logic [REG_IDX_W-1:0] src0_i,
  input  logic [REG_IDX_W-1:0] src1_i,
  output logic                 hit0_o,
  output logic                 hit1_o,
  output logic                 stall_o,
  output logic                 full_o,
  output logic                 empty_o
);
  logic          ins_fire, rem_fire;
  logic [PW-1:0] wr_ptr, rd_ptr;
  sb_entry_t     ent [DEPTH];
  logic [REG_IDX_W-1:0] srcs [NUM_SRC];
  logic [NUM_SRC-1:0]   hits;

  hsb_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ins_req_i  (ins_valid_i),
    .rem_req_i  (rem_valid_i),
    .ins_fire_o (ins_fire),
    .rem_fire_o (rem_fire),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .full_o     (full_o),
    .empty_o    (empty_o)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    hsb_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (ins_fire && (wr_ptr == PW'(g))),
      .clr_en_i  (rem_fire && (rd_ptr == PW'(g))),
      .has_dst_i (ins_has_dst_i),
      .dst_i     (ins_dst_i),
      .ent_o     (ent[g])
    );
  end

  assign srcs[0] = src0_i;
  assign srcs[1] = src1_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_search
    hsb_match #(.DEPTH(DEPTH)) u_match (
      .ent_i (ent),
      .src_i (srcs[s]),
      .hit_o (hits[s])
    );
  end

  assign hit0_o  = hits[0];
  assign hit1_o  = hits[1];
  assign stall_o = |hits;

  p_zero_idx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src0_i == '0) |-> !hit0_o) and ((src1_i == '0) |-> !hit1_o));
  p_empty_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !stall_o);
endmodule

// File: tb/hazard_scoreboard_tb.sv
module hazard_scoreboard_tb;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_v = 1'b0, ins_h = 1'b0, rem_v = 1'b0;
  logic [4:0] ins_d = '0, s0 = '0, s1 = '0;
  logic hit0, hit1, stall, full, empty;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // bench model: ordered list, index 0 is oldest
  logic       m_has [DEPTH];
  logic [4:0] m_dst [DEPTH];
  int         m_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  hazard_scoreboard #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ins_valid_i(ins_v), .ins_has_dst_i(ins_h),
    .ins_dst_i(ins_d), .rem_valid_i(rem_v), .src0_i(s0), .src1_i(s1),
    .hit0_o(hit0), .hit1_o(hit1), .stall_o(stall), .full_o(full), .empty_o(empty)
  );

  function automatic logic m_hit(input logic [4:0] s);
    logic r = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (i < m_cnt && m_has[i] && m_dst[i] == s) r = 1'b1;
    return (s != 0) && r;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0b expected=%0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    logic e0 = m_hit(s0);
    logic e1 = m_hit(s1);
    chk(tag, "hit0", hit0, e0);
    chk(tag, "hit1", hit1, e1);
    chk(tag, "stall", stall, e0 | e1);
    chk(tag, "full", full, m_cnt == DEPTH);
    chk(tag, "empty", empty, m_cnt == 0);
  endtask

  // drive at negedge, check pre-edge outputs, then let the edge happen
  task automatic step(input logic iv, input logic ih, input logic [4:0] id,
                      input logic rv, input logic [4:0] a, input logic [4:0] b,
                      input string tag);
    logic do_rem, do_ins;
    @(negedge clk);
    ins_v = iv; ins_h = ih; ins_d = id; rem_v = rv; s0 = a; s1 = b;
    #1;
    chk_all(tag);
    do_rem = rv && (m_cnt > 0);
    do_ins = iv && (m_cnt < DEPTH);
    @(posedge clk);
    if (do_rem) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        m_has[i] = m_has[i+1];
        m_dst[i] = m_dst[i+1];
      end
      m_cnt--;
    end
    if (do_ins) begin
      m_has[m_cnt] = ih;
      m_dst[m_cnt] = id;
      m_cnt++;
    end
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < 32; v++) step(0, 0, 0, 0, 5'(v), 5'(31 - v), tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_has[i] = 0; m_dst[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state over all source indices
    for (int v = 0; v < 32; v++) begin
      @(negedge clk); s0 = 5'(v); s1 = 5'(v ^ 5'h15); #1;
      chk("R1", "stall", stall, 1'b0);
      chk("R1", "empty", empty, 1'b1);
      chk("R1", "full", full, 1'b0);
    end
    // R2/R3: two pending registers, sweep each source
    step(1, 1, 3, 0, 0, 0, "R2");
    step(1, 1, 7, 0, 0, 0, "R2");
    for (int v = 0; v < 32; v++) step(0, 0, 0, 0, 5'(v), 0, "R2");
    for (int v = 0; v < 32; v++) step(0, 0, 0, 0, 0, 5'(v), "R3");
    sweep("R3");
    // R4: no-register entry and index 0 entry occupy slots, never hit
    step(1, 0, 9, 0, 9, 0, "R4");
    step(1, 1, 0, 0, 0, 9, "R4");
    sweep("R4");
    chk("R4", "full", full, 1'b1);
    // R6: insert while full is discarded, even alongside a removal
    step(1, 1, 20, 0, 20, 20, "R6");
    step(1, 1, 21, 1, 21, 3, "R6");
    sweep("R6");
    // R8: entry removed this cycle still hits; entry inserted this cycle does not
    step(0, 0, 0, 1, 7, 0, "R8");
    step(1, 1, 14, 0, 14, 0, "R8");
    step(0, 0, 0, 0, 14, 0, "R8");
    // R5: drain oldest-first with sweeps between removals
    for (int k = 0; k < DEPTH; k++) begin
      step(0, 0, 0, 1, 14, 0, "R5");
      sweep("R5");
    end
    // R7: removal on empty ignored, then normal insert
    step(0, 0, 0, 1, 0, 0, "R7");
    step(0, 0, 0, 1, 0, 0, "R7");
    step(1, 1, 11, 0, 11, 0, "R7");
    step(0, 0, 0, 0, 11, 0, "R7");
    // R9: simultaneous insert and remove keeps occupancy, order preserved
    step(1, 1, 12, 0, 0, 0, "R9");
    step(1, 1, 13, 1, 11, 12, "R9");
    step(1, 1, 11, 1, 12, 13, "R9");
    sweep("R9");
    // R5/R9: long pseudo-random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1] | lfsr[2], {2'b0, lfsr[5:3]}, lfsr[6] & lfsr[7],
           {2'b0, lfsr[10:8]}, {2'b0, lfsr[13:11]}, "R9");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule